// File: doc/BRIEF.md
# Bus-Master IDE DMA Control Registers

This block is the host-facing register file and control state of one channel of a bus-master IDE DMA engine. Software programs a 32-bit descriptor table address, picks the transfer direction, and starts the engine by setting a run bit, but only after the drive command has already been issued. The block passes run, direction and table address to a separate descriptor-walking engine. That engine reports back three events: table exhaustion, bus error and the drive's interrupt line.

From those events the block keeps three status bits: active, error and interrupt. Error and interrupt are cleared by writing 1 to them. The usual software idiom is to write back the value it read with bits 1 and 2 forced to one. The status byte also holds two plain read/write capability flags, one for each drive unit. The interrupt bit drives `irq_o`.

A small classifier decodes the three low status bits into a verdict. Exactly interrupt-set, not-active, no-error counts as a good completion. Any state with the active bit set means the transfer is still in progress. An error without activity is a failure. All-clear means the state is unknown.

Top module: `bmide_dma_regs`

## Requirements
- R1: After reset every register bit reads zero, and `eng_run_o`, `eng_dir_o`, `irq_o`, `tbl_ptr_o` and `verdict_o` are all zero.
- R2: A write to command bit 0 with value 1 while that bit is 0 sets the active status bit and `eng_run_o` at the next clock. Writing 0 to command bit 0 clears both at the next clock. Rewriting 1 while the bit is already 1 starts nothing new.
- R3: Command bit 3 sets `eng_dir_o`, where 1 means the engine writes memory (device read) and 0 means it reads memory. A write to this bit is ignored while the active bit is set.
- R4: The register map is as follows. Word address 0 holds the command byte in bits 7:0 and the status byte in bits 23:16. Word address 1 holds the table pointer. Every other word, and every unused bit, reads zero. Each byte is written only when its byte enable is set.
- R5: Status error (bit 1) and interrupt (bit 2) are cleared by writing 1 to them. Writing 0 to them leaves them unchanged. A hardware set in the same cycle as a clear wins.
- R6: Status bits 5 and 6 are read/write capability flags for drive unit 0 and unit 1. Each holds the last value written to its own bit.
- R7: A rising edge on `drv_irq_i` sets the interrupt status bit, and `irq_o` always equals that bit.
- R8: `eng_done_i` clears the active bit. When `drv_irq_i` is high in the same cycle it also sets the interrupt bit. Without it the interrupt bit is left as it was.
- R9: `eng_err_i` sets the error status bit and clears the active bit at the next clock.
- R10: The table pointer always reads with bits 1:0 zero. Writes to it while the active bit is set are ignored.
- R11: `verdict_o` decodes the status bits {interrupt, error, active} as follows: 3'b100 gives 1 (good); active set gives 2 (keep waiting); error set without active gives 3 (failed); 3'b000 gives 0 (unknown).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Word address |
| reg_be_i | input | DATA_W/8 | Byte enables for writes |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| eng_done_i | input | 1 | Engine reached end of descriptor table |
| eng_err_i | input | 1 | Engine bus error |
| drv_irq_i | input | 1 | Drive interrupt line (level) |
| eng_run_o | output | 1 | Run request to the engine (active status) |
| eng_dir_o | output | 1 | 1: write to memory, 0: read from memory |
| tbl_ptr_o | output | DATA_W | Descriptor table address, 4-byte aligned |
| irq_o | output | 1 | Interrupt to host |
| verdict_o | output | 2 | Decoded completion state |

## Verification
Some properties are checked on every cycle. A stop write always drops the run output. Error and done-with-interrupt always end activity. The pointer stays aligned and frozen while running. The direction holds steady during a run. The interrupt output agrees with the status read path. A run always decodes as "keep waiting". Other behaviour shows up only in the bench's scenarios. These include the ordering of write-one-to-clear against a same-cycle hardware set, edge rather than level sensing of the drive interrupt, the idle state after a table end with no interrupt, byte-lane merging of the pointer, and the 3'b011 "busy" state reached by restarting over a pending error.

// File: rtl/bmide_pkg.sv
package bmide_pkg;
  localparam int CMD_LANE  = 0;
  localparam int STAT_LANE = 2;

  localparam int CMD_RUN_B = 0;
  localparam int CMD_DIR_B = 3;

  localparam int ST_ACT_B  = 0;
  localparam int ST_ERR_B  = 1;
  localparam int ST_INT_B  = 2;
  localparam int ST_CAP0_B = 5;
  localparam int ST_CAP1_B = 6;

  typedef enum logic [1:0] {
    VD_NONE = 2'd0,
    VD_GOOD = 2'd1,
    VD_WAIT = 2'd2,
    VD_FAIL = 2'd3
  } verdict_e;

  typedef struct packed {
    logic cap1;
    logic cap0;
    logic intr;
    logic err;
    logic act;
  } stat_t;
endpackage

// File: rtl/bmide_cmd_reg.sv
module bmide_cmd_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic run_bit_i,
  input  logic dir_bit_i,
  input  logic act_i,
  output logic run_q_o,
  output logic dir_q_o,
  output logic start_rise_o,
  output logic stop_o
);
  logic run_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (wr_i) begin
      run_q <= run_bit_i;
      // direction is frozen for the life of a transfer
      if (!act_i) dir_q <= dir_bit_i;
    end
  end

  assign start_rise_o = wr_i & run_bit_i & ~run_q;
  assign stop_o       = wr_i & ~run_bit_i;
  assign run_q_o      = run_q;
  assign dir_q_o      = dir_q;
endmodule

// File: rtl/bmide_stat_reg.sv
module bmide_stat_reg
  import bmide_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  logic  clr_err_i,
  input  logic  clr_int_i,
  input  logic  cap0_i,
  input  logic  cap1_i,
  input  logic  start_rise_i,
  input  logic  stop_i,
  input  logic  done_i,
  input  logic  err_i,
  input  logic  drv_irq_i,
  output stat_t stat_o
);
  logic drv_q, act_q, err_q, int_q, cap0_q, cap1_q;
  logic int_set;

  assign int_set = (drv_irq_i & ~drv_q) | (done_i & drv_irq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q  <= 1'b0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      int_q  <= 1'b0;
      cap0_q <= 1'b0;
      cap1_q <= 1'b0;
    end else begin
      drv_q <= drv_irq_i;

      if (start_rise_i)                 act_q <= 1'b1;
      else if (stop_i | done_i | err_i) act_q <= 1'b0;

      // hardware set has priority over write-one-to-clear
      if (err_i)                  err_q <= 1'b1;
      else if (wr_i && clr_err_i) err_q <= 1'b0;

      if (int_set)                int_q <= 1'b1;
      else if (wr_i && clr_int_i) int_q <= 1'b0;

      if (wr_i) begin
        cap0_q <= cap0_i;
        cap1_q <= cap1_i;
      end
    end
  end

  assign stat_o = '{cap1: cap1_q, cap0: cap0_q, intr: int_q, err: err_q, act: act_q};
endmodule

// File: rtl/bmide_ptr_reg.sv
module bmide_ptr_reg #(
  parameter int DATA_W    = 32,
  parameter int PTR_ALIGN = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                lock_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   ptr_o
);
  localparam int LANES = DATA_W / 8;
  localparam logic [DATA_W-1:0] KEEP = ~((DATA_W'(1) << PTR_ALIGN) - DATA_W'(1));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LO = l * 8;
    logic [7:0] lane_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        lane_q <= '0;
      else if (wr_i && be_i[l] && !lock_i)
        lane_q <= wdata_i[LO +: 8] & KEEP[LO +: 8];
    end

    assign ptr_o[LO +: 8] = lane_q;
  end
endmodule

// File: rtl/bmide_verdict.sv
module bmide_verdict
  import bmide_pkg::*;
(
  input  logic     act_i,
  input  logic     err_i,
  input  logic     int_i,
  output verdict_e verdict_o
);
  always_comb begin
    unique case ({int_i, err_i, act_i})
      3'b100:                          verdict_o = VD_GOOD;
      3'b001, 3'b011, 3'b101, 3'b111:  verdict_o = VD_WAIT;
      3'b010, 3'b110:                  verdict_o = VD_FAIL;
      default:                         verdict_o = VD_NONE;
    endcase
  end
endmodule

// File: rtl/bmide_dma_regs.sv
module bmide_dma_regs
  import bmide_pkg::*;
#(
  parameter int REG_AW    = 2,
  parameter int DATA_W    = 32,
  parameter int PTR_ALIGN = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [DATA_W/8-1:0] reg_be_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                eng_done_i,
  input  logic                eng_err_i,
  input  logic                drv_irq_i,
  output logic                eng_run_o,
  output logic                eng_dir_o,
  output logic [DATA_W-1:0]   tbl_ptr_o,
  output logic                irq_o,
  output logic [1:0]          verdict_o
);
  localparam logic [REG_AW-1:0] CTRL_WORD = '0;
  localparam logic [REG_AW-1:0] PTR_WORD  = REG_AW'(1);
  localparam int CMD_LO  = CMD_LANE * 8;
  localparam int STAT_LO = STAT_LANE * 8;

  logic     sel_ctrl, sel_ptr, cmd_wr, stat_wr;
  logic     run_q, dir_q, start_rise, stop;
  stat_t    stat;
  verdict_e verdict;
  logic [7:0] cmd_byte, stat_byte;

  assign sel_ctrl = (reg_addr_i == CTRL_WORD);
  assign sel_ptr  = (reg_addr_i == PTR_WORD);
  assign cmd_wr   = reg_we_i & sel_ctrl & reg_be_i[CMD_LANE];
  assign stat_wr  = reg_we_i & sel_ctrl & reg_be_i[STAT_LANE];

  bmide_cmd_reg u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (cmd_wr),
    .run_bit_i    (reg_wdata_i[CMD_LO + CMD_RUN_B]),
    .dir_bit_i    (reg_wdata_i[CMD_LO + CMD_DIR_B]),
    .act_i        (stat.act),
    .run_q_o      (run_q),
    .dir_q_o      (dir_q),
    .start_rise_o (start_rise),
    .stop_o       (stop)
  );

  bmide_stat_reg u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (stat_wr),
    .clr_err_i    (reg_wdata_i[STAT_LO + ST_ERR_B]),
    .clr_int_i    (reg_wdata_i[STAT_LO + ST_INT_B]),
    .cap0_i       (reg_wdata_i[STAT_LO + ST_CAP0_B]),
    .cap1_i       (reg_wdata_i[STAT_LO + ST_CAP1_B]),
    .start_rise_i (start_rise),
    .stop_i       (stop),
    .done_i       (eng_done_i),
    .err_i        (eng_err_i),
    .drv_irq_i    (drv_irq_i),
    .stat_o       (stat)
  );

  bmide_ptr_reg #(
    .DATA_W    (DATA_W),
    .PTR_ALIGN (PTR_ALIGN)
  ) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_we_i & sel_ptr),
    .lock_i  (stat.act),
    .be_i    (reg_be_i),
    .wdata_i (reg_wdata_i),
    .ptr_o   (tbl_ptr_o)
  );

  bmide_verdict u_vd (
    .act_i     (stat.act),
    .err_i     (stat.err),
    .int_i     (stat.intr),
    .verdict_o (verdict)
  );

  always_comb begin
    cmd_byte            = '0;
    cmd_byte[CMD_RUN_B] = run_q;
    cmd_byte[CMD_DIR_B] = dir_q;
    stat_byte            = '0;
    stat_byte[ST_ACT_B]  = stat.act;
    stat_byte[ST_ERR_B]  = stat.err;
    stat_byte[ST_INT_B]  = stat.intr;
    stat_byte[ST_CAP0_B] = stat.cap0;
    stat_byte[ST_CAP1_B] = stat.cap1;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_ctrl) begin
      reg_rdata_o[CMD_LO  +: 8] = cmd_byte;
      reg_rdata_o[STAT_LO +: 8] = stat_byte;
    end else if (sel_ptr) begin
      reg_rdata_o = tbl_ptr_o;
    end
  end

  assign eng_run_o = stat.act;
  assign eng_dir_o = dir_q;
  assign irq_o     = stat.intr;
  assign verdict_o = verdict;
endmodule

// File: rtl/bmide_dma_regs_chk.sv
module bmide_dma_regs_chk #(
  parameter int REG_AW    = 2,
  parameter int DATA_W    = 32,
  parameter int PTR_ALIGN = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [REG_AW-1:0]   reg_addr_i,
  input logic [DATA_W/8-1:0] reg_be_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic [DATA_W-1:0]   reg_rdata_o,
  input logic                eng_done_i,
  input logic                eng_err_i,
  input logic                drv_irq_i,
  input logic                eng_run_o,
  input logic                eng_dir_o,
  input logic [DATA_W-1:0]   tbl_ptr_o,
  input logic                irq_o,
  input logic [1:0]          verdict_o
);
  logic ctrl_rd, ptr_wr, ctrl_wr;
  assign ctrl_rd = (reg_addr_i == '0);
  assign ptr_wr  = reg_we_i && (reg_addr_i == REG_AW'(1));
  assign ctrl_wr = reg_we_i && ctrl_rd;

  // R2
  stop_drops_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_be_i[0] && !reg_wdata_i[0]) |=> !eng_run_o);

  // R3
  dir_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_run_o |=> $stable(eng_dir_o));

  // R7
  irq_matches_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |-> (reg_rdata_o[18] == irq_o));

  // R8
  done_with_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && drv_irq_i && !reg_we_i) |=> (irq_o && !eng_run_o));

  // R9
  err_ends_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_err_i && !reg_we_i) |=> (!eng_run_o && verdict_o == 2'd3));

  // R10
  ptr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_ptr_o[PTR_ALIGN-1:0] == '0);

  // R10
  ptr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_wr && eng_run_o) |=> $stable(tbl_ptr_o));

  // R11
  run_means_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_run_o |-> verdict_o == 2'd2);

  // R11
  clean_done_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd && irq_o && !eng_run_o && !reg_rdata_o[17]) |-> verdict_o == 2'd1);
endmodule

bind bmide_dma_regs bmide_dma_regs_chk #(
  .REG_AW    (REG_AW),
  .DATA_W    (DATA_W),
  .PTR_ALIGN (PTR_ALIGN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_be_i    (reg_be_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .eng_done_i  (eng_done_i),
  .eng_err_i   (eng_err_i),
  .drv_irq_i   (drv_irq_i),
  .eng_run_o   (eng_run_o),
  .eng_dir_o   (eng_dir_o),
  .tbl_ptr_o   (tbl_ptr_o),
  .irq_o       (irq_o),
  .verdict_o   (verdict_o)
);

// File: tb/tb_bmide_dma_regs.sv
`timescale 1ns/1ps
module tb_bmide_dma_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [3:0]  reg_be_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        eng_done_i = 1'b0, eng_err_i = 1'b0, drv_irq_i = 1'b0;
  logic        eng_run_o, eng_dir_o, irq_o;
  logic [31:0] tbl_ptr_o;
  logic [1:0]  verdict_o;

  always #2.5 clk = ~clk;

  bmide_dma_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_be_i(reg_be_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .eng_done_i(eng_done_i), .eng_err_i(eng_err_i), .drv_irq_i(drv_irq_i),
    .eng_run_o(eng_run_o), .eng_dir_o(eng_dir_o), .tbl_ptr_o(tbl_ptr_o),
    .irq_o(irq_o), .verdict_o(verdict_o)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural reference state
  bit m_run, m_dir, m_act, m_err, m_int, m_cap0, m_cap1, m_drv_prev;
  logic [31:0] m_ptr;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s/%s t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_verdict();
    if (m_int && !m_act && !m_err) return 2'd1;
    if (m_act)                     return 2'd2;
    if (m_err)                     return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [31:0] exp_rdata(logic [1:0] a);
    logic [31:0] r = '0;
    if (a == 2'd0) begin
      r[0] = m_run; r[3] = m_dir;
      r[16] = m_act; r[17] = m_err; r[18] = m_int; r[21] = m_cap0; r[22] = m_cap1;
    end else if (a == 2'd1) r = m_ptr;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      {m_run, m_dir, m_act, m_err, m_int, m_cap0, m_cap1, m_drv_prev} = '0;
      m_ptr = '0;
    end else begin
      bit cw, sw, pw, rise, old_act;
      cw = reg_we_i && reg_addr_i == 0 && reg_be_i[0];
      sw = reg_we_i && reg_addr_i == 0 && reg_be_i[2];
      pw = reg_we_i && reg_addr_i == 1;
      old_act = m_act;
      rise = cw && reg_wdata_i[0] && !m_run;
      if (rise) m_act = 1;
      else if ((cw && !reg_wdata_i[0]) || eng_done_i || eng_err_i) m_act = 0;
      if (cw) begin
        if (!old_act) m_dir = reg_wdata_i[3];
        m_run = reg_wdata_i[0];
      end
      if (eng_err_i) m_err = 1; else if (sw && reg_wdata_i[17]) m_err = 0;
      if ((drv_irq_i && !m_drv_prev) || (eng_done_i && drv_irq_i)) m_int = 1;
      else if (sw && reg_wdata_i[18]) m_int = 0;
      if (sw) begin m_cap0 = reg_wdata_i[21]; m_cap1 = reg_wdata_i[22]; end
      if (pw && !old_act)
        for (int l = 0; l < 4; l++)
          if (reg_be_i[l]) m_ptr[l*8 +: 8] = reg_wdata_i[l*8 +: 8];
      m_ptr[1:0] = 2'b00;
      m_drv_prev = drv_irq_i;
    end
    #1;
    check("R2", {31'b0, eng_run_o}, {31'b0, m_act});
    check("R3", {31'b0, eng_dir_o}, {31'b0, m_dir});
    check("R10", tbl_ptr_o, m_ptr);
    check("R7", {31'b0, irq_o}, {31'b0, m_int});
    check("R11", {30'b0, verdict_o}, {30'b0, exp_verdict()});
    check("R4", reg_rdata_o, exp_rdata(reg_addr_i));
  end

  task automatic step(bit we, logic [1:0] a, logic [3:0] be, logic [31:0] d,
                      bit done = 0, bit err = 0);
    reg_we_i = we; reg_addr_i = a; reg_be_i = be; reg_wdata_i = d;
    eng_done_i = done; eng_err_i = err;
    @(negedge clk);
  endtask

  task automatic idle(logic [1:0] a, int n = 1);
    for (int i = 0; i < n; i++) step(0, a, 4'h0, 32'h0);
  endtask

  initial begin
    logic [31:0] x;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    idle(0, 2); idle(1); idle(3);

    phase = "R10_ptr";
    step(1, 1, 4'hF, 32'h1234_5677); idle(1);
    step(1, 1, 4'h2, 32'h0000_AB00); idle(1);

    phase = "R6_cap";
    step(1, 0, 4'h4, 32'h0020_0000); idle(0);
    step(1, 0, 4'h4, 32'h0040_0000); idle(0);
    step(1, 0, 4'h4, 32'h0060_0000); idle(0);

    phase = "R3_R2_start";
    step(1, 0, 4'h1, 32'h0000_0008); idle(0);
    step(1, 0, 4'h1, 32'h0000_0009); idle(0);
    step(1, 0, 4'h1, 32'h0000_0001); idle(0);   // dir write ignored while active
    step(1, 1, 4'hF, 32'hDEAD_BEEF); idle(1);   // R10 pointer locked
    phase = "R7_drv_early";
    drv_irq_i = 1; idle(0, 2);
    phase = "R8_done_irq";
    step(0, 0, 4'h0, 0, 1, 0); idle(0);
    drv_irq_i = 0; idle(0);
    phase = "R5_w1c";
    step(1, 0, 4'h4, 32'h0060_0000); idle(0);   // zeros leave bits
    step(1, 0, 4'h4, 32'h0066_0000); idle(0);
    step(1, 0, 4'h1, 32'h0000_0000); idle(0);

    phase = "R9_err";
    step(1, 0, 4'h1, 32'h0000_0001); idle(0);
    step(0, 0, 4'h0, 0, 0, 1); idle(0, 2);
    phase = "R11_busy_restart";
    step(1, 0, 4'h1, 32'h0000_0000);
    step(1, 0, 4'h1, 32'h0000_0001); idle(0);   // 3'b011
    step(1, 0, 4'h1, 32'h0000_0001); idle(0);   // rewrite 1: no new start
    phase = "R5_clear_err";
    step(1, 0, 4'h1, 32'h0000_0000);
    step(1, 0, 4'h4, 32'h0002_0000); idle(0);

    phase = "R8_done_no_irq";
    step(1, 0, 4'h1, 32'h0000_0001);
    step(0, 0, 4'h0, 0, 1, 0); idle(0, 2);
    step(1, 0, 4'h1, 32'h0000_0000);

    phase = "R5_set_wins";
    step(1, 0, 4'h1, 32'h0000_0001);
    drv_irq_i = 1;
    step(1, 0, 4'h4, 32'h0004_0000); idle(0);
    step(1, 0, 4'h4, 32'h0004_0000); idle(0);   // level held: clear sticks
    drv_irq_i = 0;
    step(1, 0, 4'h1, 32'h0000_0000); idle(0);

    phase = "R4_mixed";
    x = 32'h1BAD_5EED;
    for (int i = 0; i < 600; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      drv_irq_i = x[30] ^ x[7];
      step(x[0] & x[1], x[3:2], x[7:4], {x[31:8], x[23:16]},
           (x[11:9] == 3'b101), (x[15:12] == 4'hA));
    end
    idle(0, 2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule